// File: doc/BRIEF.md
# Triggered Converter Data Interface

This block is the digital front end for two converter channels. Software or a DMA engine loads a holding value for each channel through a small register write port. The value can be written as 12 bits aligned to the low end, 12 bits aligned to the high end, or 8 bits. A single dual write can also pack one byte for each channel so that both channels update together. The analog ladder and its output buffer sit outside this block. They consume the two 12-bit output codes.

When a channel's trigger is enabled, the output code changes only at the clock edge where the selected trigger line is high. The output timing therefore follows the trigger and not the write. Each triggered transfer raises a DMA request for the next sample. If a further trigger arrives before that request is acknowledged, a sticky underrun flag is set. A channel can also add either LFSR noise or a triangle ramp to the holding value on every trigger, with saturation at full scale. When the trigger is disabled, the output simply follows the holding register with one clock of delay.

Top module: `trigdac_front`

## Requirements
- R1: After reset, both output codes are 0x000 and `dmaReq` and `underrunIrq` are low.
- R2: A write to address 0 (channel 0) or address 3 (channel 1) loads that channel's holding value from `wrData[11:0]`. Bits 15:12 are ignored.
- R3: A write to address 1 (channel 0) or address 4 (channel 1) loads the holding value from `wrData[15:4]`.
- R4: A write to address 2 (channel 0) or address 5 (channel 1) loads `wrData[7:0]` into bits 11:4 of the holding value, with bits 3:0 cleared.
- R5: A write to address 6 loads channel 0 from `wrData[7:0]` and channel 1 from `wrData[15:8]` in the same cycle. Each byte goes into bits 11:4 of its channel's holding value.
- R6: With a channel's trigger disabled, its output code equals the holding value one clock after the holding register is loaded. In other words, the output changes at the second rising edge after `wrEn` is sampled.
- R7: With a channel's trigger enabled, writes and non-selected trigger lines leave the output unchanged. The output takes the transfer value at the edge where the selected line is high. Select codes 0 to 5 pick `tmrTrig[code]`, code 6 picks `extTrig`, and code 7 picks a software trigger, which is a write to address 7 with bit 0 (channel 0) or bit 1 (channel 1) set.
- R8: A triggered transfer sets the channel's `dmaReq` at that edge. The request stays high until the edge at which `dmaAck` is sampled high.
- R9: A trigger that arrives while `dmaReq` is high and `dmaAck` is low sets `underrunIrq`, and the transfer still happens. The flag stays set until a write to address 7 with bit 4 (channel 0) or bit 5 (channel 1) set.
- R10: Wave mode 1 (noise) uses a 12-bit LFSR that starts at 0xACE and shifts left. The new bit 0 is the XOR of bits 11, 5, 3 and 0. On each trigger the output is the holding value plus the LFSR value masked to its low `amp+1` bits, where amp is clamped to 11. After the transfer the LFSR advances.
- R11: Wave mode 2 (triangle) adds a ramp offset that starts at 0 and steps once per trigger. The offset counts up to a peak of 2^(amp+1)-1 and then back down to 0, giving offsets 0,1,…,peak,peak-1,…,0,1,… across successive transfers.
- R12: The sum of the holding value and the wave offset saturates at 0xFFF.
- R13: In wave modes 0 and 3, a trigger transfers the holding value unchanged, and neither generator advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address (format/channel/command) |
| wrData | input | 16 | Write data |
| trigEn | input | 2 | Per-channel trigger enable |
| trigSel | input | 6 | Per-channel trigger select, 3 bits each |
| waveMode | input | 4 | Per-channel wave mode, 2 bits each |
| waveAmp | input | 8 | Per-channel wave amplitude, 4 bits each |
| tmrTrig | input | 6 | Timer trigger pulses |
| extTrig | input | 1 | External trigger pulse |
| dmaAck | input | 2 | Per-channel DMA acknowledge |
| dout0 | output | 12 | Channel 0 output code |
| dout1 | output | 12 | Channel 1 output code |
| dmaReq | output | 2 | Per-channel DMA request |
| underrunIrq | output | 2 | Per-channel sticky underrun flag |

## Verification
A wrong holding register or format decode shows up one clock after the write when the trigger is disabled, or at the next trigger otherwise. A generator with a bad state only becomes visible at transfers in noise or triangle mode. A single step out of sequence shifts every later output, so a run of consecutive triggers checked against a model exposes it within one or two samples. A faulty request or underrun state shows at the edge immediately after the trigger or the acknowledge, because both flags are registered directly at the ports.

// File: rtl/trigdac_pkg.sv
package trigdac_pkg;
  typedef enum logic [2:0] {
    FMT_R12 = 3'd0,
    FMT_L12 = 3'd1,
    FMT_R8  = 3'd2,
    FMT_DLO = 3'd3,
    FMT_DHI = 3'd4
  } holdFmt_e;

  typedef enum logic [1:0] {
    WAVE_NONE  = 2'd0,
    WAVE_NOISE = 2'd1,
    WAVE_RAMP  = 2'd2,
    WAVE_RSVD  = 2'd3
  } wave_e;

  typedef struct packed {
    logic     holdWr;
    holdFmt_e fmt;
    logic     xfer;
    logic     step;
  } dpStrobe_t;
endpackage

// File: rtl/trigdac_lfsr.sv
module trigdac_lfsr #(
  parameter int W = 12,
  parameter logic [W-1:0] SEED = 12'hACE,
  parameter logic [W-1:0] TAPS = 12'h829
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         adv,
  output logic [W-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rstN) state <= SEED;
    else if (adv) state <= {state[W-2:0], ^(state & TAPS)};
  end

  // R10
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);
endmodule

// File: rtl/trigdac_ramp.sv
module trigdac_ramp #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         adv,
  input  logic [W-1:0] peak,
  output logic [W-1:0] value
);
  logic goingUp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      value   <= '0;
      goingUp <= 1'b1;
    end else if (adv) begin
      if (goingUp) begin
        if (value >= peak) begin
          goingUp <= 1'b0;
          value   <= (value == '0) ? value : value - 1'b1;
        end else begin
          value <= value + 1'b1;
        end
      end else if (value == '0) begin
        goingUp <= 1'b1;
        value   <= value + 1'b1;
      end else begin
        value <= value - 1'b1;
      end
    end
  end

  // R11
  ramp_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adv && value == '0 && peak != '0) |=> value == W'(1));
endmodule

// File: rtl/trigdac_ctrl.sv
module trigdac_ctrl
  import trigdac_pkg::*;
#(
  parameter int CH_IDX = 0,
  parameter int SEL_W  = 3,
  parameter int WR_W   = 16,
  localparam int NUM_HW = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [WR_W-1:0]  wrData,
  input  logic             trigEn,
  input  logic [SEL_W-1:0] trigSel,
  input  logic [NUM_HW-1:0] hwLines,
  input  logic             dmaAck,
  output dpStrobe_t        strobe,
  output logic             dmaReq,
  output logic             underrun
);
  localparam logic [2:0] BASE      = 3'(CH_IDX * 3);
  localparam logic [2:0] ADDR_DUAL = 3'd6;
  localparam logic [2:0] ADDR_CMD  = 3'd7;

  logic cmdWr, swHit, clrHit, trigHit;
  logic [NUM_HW:0] lines;

  assign cmdWr   = wrEn && (wrAddr == ADDR_CMD);
  assign swHit   = cmdWr && wrData[CH_IDX];
  assign clrHit  = cmdWr && wrData[4 + CH_IDX];
  assign lines   = {swHit, hwLines};
  assign trigHit = trigEn && lines[trigSel];

  always_comb begin
    strobe     = '0;
    strobe.fmt = FMT_R12;
    if (wrEn) begin
      if (wrAddr == BASE) begin
        strobe.holdWr = 1'b1;
        strobe.fmt    = FMT_R12;
      end else if (wrAddr == BASE + 3'd1) begin
        strobe.holdWr = 1'b1;
        strobe.fmt    = FMT_L12;
      end else if (wrAddr == BASE + 3'd2) begin
        strobe.holdWr = 1'b1;
        strobe.fmt    = FMT_R8;
      end else if (wrAddr == ADDR_DUAL) begin
        strobe.holdWr = 1'b1;
        strobe.fmt    = (CH_IDX == 0) ? FMT_DLO : FMT_DHI;
      end
    end
    strobe.xfer = trigEn ? trigHit : 1'b1;
    strobe.step = trigHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaReq   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (trigHit) dmaReq <= 1'b1;
      else if (dmaAck) dmaReq <= 1'b0;
      if (trigHit && dmaReq && !dmaAck) underrun <= 1'b1;
      else if (clrHit) underrun <= 1'b0;
    end
  end

  // R8
  req_on_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trigEn && strobe.xfer) |=> dmaReq);
  // R8
  ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && !strobe.step) |=> !dmaReq);
  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !clrHit) |=> underrun);
endmodule

// File: rtl/trigdac_dp.sv
module trigdac_dp
  import trigdac_pkg::*;
#(
  parameter int DW    = 12,
  parameter int WR_W  = 16,
  parameter int AMP_W = 4,
  parameter logic [DW-1:0] SEED = 12'hACE,
  parameter logic [DW-1:0] TAPS = 12'h829
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WR_W-1:0]  wrData,
  input  logic [1:0]       waveMode,
  input  logic [AMP_W-1:0] waveAmp,
  output logic [DW-1:0]    dout
);
  localparam int PAD = DW - 8;

  logic [DW-1:0] hold, holdNext, mask, noiseVal, rampVal, addend, satVal;
  logic [DW:0]   sum;
  logic          noiseAdv, rampAdv;

  function automatic logic [DW-1:0] ampMask(input logic [AMP_W-1:0] amp);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i <= int'(amp));
    return m;
  endfunction

  always_comb begin
    unique case (strobe.fmt)
      FMT_L12: holdNext = wrData[WR_W-1 -: DW];
      FMT_R8,
      FMT_DLO: holdNext = {wrData[7:0], {PAD{1'b0}}};
      FMT_DHI: holdNext = {wrData[15:8], {PAD{1'b0}}};
      default: holdNext = wrData[DW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) hold <= '0;
    else if (strobe.holdWr) hold <= holdNext;
  end

  assign mask     = ampMask(waveAmp);
  assign noiseAdv = strobe.step && (waveMode == WAVE_NOISE);
  assign rampAdv  = strobe.step && (waveMode == WAVE_RAMP);

  trigdac_lfsr #(.W(DW), .SEED(SEED), .TAPS(TAPS)) uNoise (
    .clk(clk), .rstN(rstN), .adv(noiseAdv), .state(noiseVal));

  trigdac_ramp #(.W(DW)) uRamp (
    .clk(clk), .rstN(rstN), .adv(rampAdv), .peak(mask), .value(rampVal));

  always_comb begin
    addend = '0;
    if (strobe.step) begin
      if (waveMode == WAVE_NOISE) addend = noiseVal & mask;
      else if (waveMode == WAVE_RAMP) addend = rampVal;
    end
  end

  assign sum    = {1'b0, hold} + {1'b0, addend};
  assign satVal = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) dout <= '0;
    else if (strobe.xfer) dout <= satVal;
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xfer |=> $stable(dout));
  // R12
  sat_nowrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |=> dout >= $past(hold));
endmodule

// File: rtl/trigdac_front.sv
module trigdac_front
  import trigdac_pkg::*;
#(
  parameter int DW    = 12,
  parameter int WR_W  = 16,
  parameter int AMP_W = 4,
  parameter int SEL_W = 3,
  parameter int N_TMR = 6,
  localparam int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [2:0]               wrAddr,
  input  logic [WR_W-1:0]          wrData,
  input  logic [NUM_CH-1:0]        trigEn,
  input  logic [NUM_CH*SEL_W-1:0]  trigSel,
  input  logic [NUM_CH*2-1:0]      waveMode,
  input  logic [NUM_CH*AMP_W-1:0]  waveAmp,
  input  logic [N_TMR-1:0]         tmrTrig,
  input  logic                     extTrig,
  input  logic [NUM_CH-1:0]        dmaAck,
  output logic [DW-1:0]            dout0,
  output logic [DW-1:0]            dout1,
  output logic [NUM_CH-1:0]        dmaReq,
  output logic [NUM_CH-1:0]        underrunIrq
);
  localparam int NUM_HW = (1 << SEL_W) - 1;

  logic [NUM_HW-1:0] hwLines;
  logic [DW-1:0]     chOut [NUM_CH];

  assign hwLines = {extTrig, tmrTrig};

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    dpStrobe_t strobe;

    trigdac_ctrl #(.CH_IDX(c), .SEL_W(SEL_W), .WR_W(WR_W)) uCtrl (
      .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
      .trigEn(trigEn[c]), .trigSel(trigSel[c*SEL_W +: SEL_W]),
      .hwLines(hwLines), .dmaAck(dmaAck[c]), .strobe(strobe),
      .dmaReq(dmaReq[c]), .underrun(underrunIrq[c]));

    trigdac_dp #(.DW(DW), .WR_W(WR_W), .AMP_W(AMP_W)) uDp (
      .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
      .waveMode(waveMode[c*2 +: 2]), .waveAmp(waveAmp[c*AMP_W +: AMP_W]),
      .dout(chOut[c]));
  end

  assign dout0 = chOut[0];
  assign dout1 = chOut[1];
endmodule

// File: tb/tb_trigdac_front.sv
module tb_trigdac_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  trigEn = '0;
  logic [5:0]  trigSel = '0;
  logic [3:0]  waveMode = '0;
  logic [7:0]  waveAmp = '0;
  logic [5:0]  tmrTrig = '0;
  logic        extTrig = 1'b0;
  logic [1:0]  dmaAck = '0;
  logic [11:0] dout0, dout1;
  logic [1:0]  dmaReq, underrunIrq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  trigdac_front dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .trigEn(trigEn), .trigSel(trigSel), .waveMode(waveMode), .waveAmp(waveAmp),
    .tmrTrig(tmrTrig), .extTrig(extTrig), .dmaAck(dmaAck),
    .dout0(dout0), .dout1(dout1), .dmaReq(dmaReq), .underrunIrq(underrunIrq));

  // {addr, data, expected ch0, expected ch1}
  localparam logic [43:0] VEC [0:7] = '{
    44'h0_0123_123_000,  // R2
    44'h1_ABC0_ABC_000,  // R3
    44'h2_00F5_F50_000,  // R4
    44'h3_0FED_F50_FED,  // R2
    44'h4_1230_F50_123,  // R3
    44'h5_0077_F50_770,  // R4
    44'h6_5A3C_3C0_5A0,  // R5
    44'h0_F456_456_5A0   // R2
  };

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseTmr(input int idx);
    @(negedge clk);
    tmrTrig[idx] = 1'b1;
    @(negedge clk);
    tmrTrig = '0;
  endtask

  function automatic logic [11:0] sat(input logic [11:0] a, input logic [11:0] b);
    logic [12:0] s = {1'b0, a} + {1'b0, b};
    return s[12] ? 12'hFFF : s[11:0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] lf;
    logic [11:0] rv;
    logic        up;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 dout0", dout0, 12'h000);
    chk("R1 dout1", dout1, 12'h000);
    chk("R1 dmaReq", {10'd0, dmaReq}, 12'h000);
    chk("R1 underrun", {10'd0, underrunIrq}, 12'h000);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][42:40], VEC[i][39:24]);
      @(negedge clk);
      chk("R2-format ch0", dout0, VEC[i][23:12]);
      chk("R2-format ch1", dout1, VEC[i][11:0]);
    end

    // R6: one clock delay after hold load
    wr(3'd0, 16'h0789);
    chk("R6 not yet", dout0, 12'h456);
    @(negedge clk);
    chk("R6 follows", dout0, 12'h789);

    // R7: triggered channel 0 on timer 2
    trigSel = 6'b000_010;
    trigEn  = 2'b01;
    wr(3'd0, 16'h0111);
    repeat (2) @(negedge clk);
    chk("R7 write ignored", dout0, 12'h789);
    pulseTmr(3);
    chk("R7 other line ignored", dout0, 12'h789);
    chk("R7 no req", {11'd0, dmaReq[0]}, 12'h000);
    pulseTmr(2);
    chk("R7 transfer", dout0, 12'h111);
    chk("R8 req set", {11'd0, dmaReq[0]}, 12'h001);
    @(negedge clk); dmaAck[0] = 1'b1;
    @(negedge clk); dmaAck[0] = 1'b0;
    chk("R8 req cleared", {11'd0, dmaReq[0]}, 12'h000);
    pulseTmr(2);
    chk("R9 no underrun", {11'd0, underrunIrq[0]}, 12'h000);
    wr(3'd0, 16'h0222);
    pulseTmr(2);
    chk("R9 underrun set", {11'd0, underrunIrq[0]}, 12'h001);
    chk("R9 transfer kept", dout0, 12'h222);
    repeat (3) @(negedge clk);
    chk("R9 sticky", {11'd0, underrunIrq[0]}, 12'h001);
    wr(3'd7, 16'h0010);
    chk("R9 cleared", {11'd0, underrunIrq[0]}, 12'h000);

    // R7: external and software triggers
    dmaAck[0] = 1'b1;
    trigSel = 6'b000_110;
    wr(3'd0, 16'h0333);
    @(negedge clk); extTrig = 1'b1;
    @(negedge clk); extTrig = 1'b0;
    chk("R7 ext trigger", dout0, 12'h333);
    trigSel = 6'b000_111;
    wr(3'd0, 16'h0444);
    chk("R7 sw pending", dout0, 12'h333);
    wr(3'd7, 16'h0001);
    chk("R7 sw trigger", dout0, 12'h444);

    // R13: wave mode 3 is plain transfer
    trigSel = 6'b000_000;
    waveMode = 4'b0011;
    pulseTmr(0);
    chk("R13 mode3 plain", dout0, 12'h444);

    // R10: noise
    waveMode = 4'b0001;
    waveAmp  = 8'h03;
    wr(3'd0, 16'h0100);
    lf = 12'hACE;
    for (int k = 0; k < 6; k++) begin
      pulseTmr(0);
      chk("R10 noise", dout0, sat(12'h100, lf & 12'h00F));
      lf = {lf[10:0], ^(lf & 12'h829)};
    end

    // R11: triangle, peak 3
    waveMode = 4'b0010;
    waveAmp  = 8'h01;
    wr(3'd0, 16'h0200);
    rv = 12'h000; up = 1'b1;
    for (int k = 0; k < 8; k++) begin
      pulseTmr(0);
      chk("R11 ramp", dout0, 12'h200 + rv);
      if (up) begin
        if (rv >= 12'd3) begin up = 1'b0; rv = rv - 1'b1; end
        else rv = rv + 1'b1;
      end else if (rv == 12'd0) begin up = 1'b1; rv = rv + 1'b1; end
      else rv = rv - 1'b1;
    end

    // R12: saturation
    wr(3'd0, 16'h0FFD);
    for (int k = 0; k < 4; k++) begin
      pulseTmr(0);
      chk("R12 saturate", dout0, sat(12'hFFD, rv));
      if (up) begin
        if (rv >= 12'd3) begin up = 1'b0; rv = rv - 1'b1; end
        else rv = rv + 1'b1;
      end else if (rv == 12'd0) begin up = 1'b1; rv = rv + 1'b1; end
      else rv = rv - 1'b1;
    end

    // R13: mode 0 leaves the noise generator where it was
    waveMode = 4'b0000;
    wr(3'd0, 16'h0100);
    pulseTmr(0);
    chk("R13 mode0 plain", dout0, 12'h100);
    waveMode = 4'b0001;
    waveAmp  = 8'h03;
    pulseTmr(0);
    chk("R13 noise resumed", dout0, sat(12'h100, lf & 12'h00F));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule